// File: doc/BRIEF.md
# Pipelined Bit-Slice Adder

This block adds a continuous stream of unsigned operand pairs and can accept a new pair on every clock. The addition is cut into equal bit slices. Each slice is handled by its own pipeline stage. A stage adds one slice of its pair, together with the carry that the previous stage stored. It registers the slice sum and its carry-out for the next stage. While stage k works on slice k of one pair, stage k-1 works on slice k-1 of the next pair, so several additions are in progress at the same time.

The operand bits that no stage has used yet travel through skew registers next to each pair. The lower sum bits already produced are delayed in the same way, so the whole sum leaves the last stage in one word. A valid bit goes with every pair. The result appears a fixed number of cycles after the pair enters, and that number is the stage count. Once the pipe is full, one result completes on every clock. The carry into the lowest slice is zero, and the carry out of the top slice is reported as the overflow bit.

Top module: `serial_pipe_adder`

## Requirements
- R1: When `res_vld` is high, `res_sum` equals the low OP_W bits of the unsigned sum of the operand pair it belongs to.
- R2: When `res_vld` is high, `res_ovf` equals bit OP_W of that unsigned sum. This is the carry out of the top slice.
- R3: A pair presented with `op_vld` high in the cycle before clock edge t appears with `res_vld` high after edge t+STAGES-1, where STAGES = OP_W/SLICE_W. With the defaults this is 8 cycles of latency.
- R4: Pairs presented on consecutive cycles produce results on consecutive cycles in the same order, one per clock, without interfering with each other.
- R5: A cycle with `op_vld` low produces a cycle with `res_vld` low exactly STAGES cycles later. Bubbles are kept in place.
- R6: Synchronous active-high `rst` clears every valid bit. Pairs in flight when `rst` is asserted never produce `res_vld`, and `res_vld` stays low until new pairs have passed through the pipe.
- R7: The carry into the lowest slice is zero, and carries pass across every slice boundary. An all-ones operand plus one gives a zero sum with `res_ovf` high.
- R8: OP_W must be a whole multiple of SLICE_W. A slice of width 1 is a full adder (XOR sum, majority carry). A wider slice uses carry-lookahead. Either way, each slice's sum and carry equal the arithmetic sum of its bits plus its carry-in.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset, clears valid bits |
| op_vld | input | 1 | Operand pair is present this cycle |
| op_a | input | OP_W | First operand |
| op_b | input | OP_W | Second operand |
| res_vld | output | 1 | Result is present this cycle |
| res_sum | output | OP_W | Sum, modulo 2^OP_W |
| res_ovf | output | 1 | Carry out of the most significant slice |

## Verification
A stage whose carry flop or slice logic is wrong corrupts only the slice positions at and above that stage. The error shows on `res_sum` or `res_ovf` exactly STAGES cycles after the affected pair enters. The vectors are chosen so that carries must travel across every slice boundary. If a skew register is wrong, a result mixes in bits from a neighbouring pair, which back-to-back distinct vectors expose on the next result. A valid bit that is stuck, or a reset that does not clear a stage, shows as `res_vld` high during a bubble or in the cycles right after reset.

// File: rtl/spa_pkg.sv
package spa_pkg;
   function automatic int stage_count(input int op_w, input int slice_w);
      return op_w / slice_w;
   endfunction

   function automatic int cnt_width(input int n);
      int w;
      w = 1;
      while ((1 << w) <= n) w++;
      return w;
   endfunction
endpackage

// File: rtl/spa_slice_add.sv
module spa_slice_add #(
   parameter int SLICE_W = 4
) (
   input  logic [SLICE_W-1:0] a,
   input  logic [SLICE_W-1:0] b,
   input  logic               cin,
   output logic [SLICE_W-1:0] sum,
   output logic               cout
);
   generate
      if (SLICE_W == 1) begin : g_full_adder
         // single bit: xor sum, majority carry
         assign sum  = a ^ b ^ cin;
         assign cout = (a[0] & b[0]) | (a[0] & cin) | (b[0] & cin);
      end else begin : g_lookahead
         logic [SLICE_W-1:0] gen;
         logic [SLICE_W-1:0] prop;
         logic [SLICE_W:0]   cy;
         assign gen  = a & b;
         assign prop = a ^ b;
         // every carry expanded as a flat sum of products over gen/prop
         always_comb begin
            cy[0] = cin;
            for (int i = 0; i < SLICE_W; i++) begin
               logic term;
               logic acc;
               acc = 1'b0;
               for (int j = 0; j <= i; j++) begin
                  term = gen[j];
                  for (int k = j + 1; k <= i; k++) term = term & prop[k];
                  acc = acc | term;
               end
               term = cin;
               for (int k = 0; k <= i; k++) term = term & prop[k];
               cy[i+1] = acc | term;
            end
         end
         assign sum  = prop ^ cy[SLICE_W-1:0];
         assign cout = cy[SLICE_W];
      end
   endgenerate
endmodule

// File: rtl/spa_stage.sv
module spa_stage #(
   parameter int SLICE_W = 4
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               in_valid,
   input  logic               in_carry,
   input  logic [SLICE_W-1:0] in_a,
   input  logic [SLICE_W-1:0] in_b,
   output logic               out_valid,
   output logic               out_carry,
   output logic [SLICE_W-1:0] out_sum
);
   logic [SLICE_W-1:0] slice_sum;
   logic               slice_cout;

   spa_slice_add #(.SLICE_W(SLICE_W)) u_add (
      .a   (in_a),
      .b   (in_b),
      .cin (in_carry),
      .sum (slice_sum),
      .cout(slice_cout)
   );

   always_ff @(posedge clk) begin
      if (rst) out_valid <= 1'b0;
      else     out_valid <= in_valid;
      out_carry <= slice_cout;
      out_sum   <= slice_sum;
   end

   // arithmetic reference for the slice, separate from the gate network
   logic [SLICE_W:0] ref_total;
   assign ref_total = {1'b0, in_a} + {1'b0, in_b} + {{SLICE_W{1'b0}}, in_carry};

   p_slice_sum_r1: assert property (@(posedge clk) disable iff (rst)
      in_valid |=> out_sum == $past(ref_total[SLICE_W-1:0]))
      else $error("slice sum mismatch");

   p_slice_carry_r2: assert property (@(posedge clk) disable iff (rst)
      in_valid |=> out_carry == $past(ref_total[SLICE_W]))
      else $error("slice carry mismatch");
endmodule

// File: rtl/serial_pipe_adder.sv
module serial_pipe_adder #(
   parameter int OP_W    = 32,
   parameter int SLICE_W = 4
) (
   input  logic            clk,
   input  logic            rst,
   input  logic            op_vld,
   input  logic [OP_W-1:0] op_a,
   input  logic [OP_W-1:0] op_b,
   output logic            res_vld,
   output logic [OP_W-1:0] res_sum,
   output logic            res_ovf
);
   localparam int STAGES = spa_pkg::stage_count(OP_W, SLICE_W);
   localparam int CNT_W  = spa_pkg::cnt_width(STAGES + 1);

   generate
      if (SLICE_W < 1 || OP_W < SLICE_W || (OP_W % SLICE_W) != 0) begin : g_bad_cfg
         $error("OP_W must be a positive multiple of SLICE_W");
      end
   endgenerate

   // operands and partial sums aligned to the input of stage k
   logic [OP_W-1:0] a_skew   [STAGES];
   logic [OP_W-1:0] b_skew   [STAGES];
   logic [OP_W-1:0] sum_skew [STAGES];
   logic [OP_W-1:0] sum_full [STAGES];
   logic            vld_q    [STAGES];
   logic            cy_q     [STAGES];
   logic [SLICE_W-1:0] slc_q [STAGES];

   assign a_skew[0]   = op_a;
   assign b_skew[0]   = op_b;
   assign sum_skew[0] = '0;

   genvar k;
   generate
      for (k = 0; k < STAGES; k++) begin : g_stage
         logic vld_in;
         logic cy_in;
         if (k == 0) begin : g_head
            assign vld_in = op_vld;
            assign cy_in  = 1'b0;
         end else begin : g_body
            assign vld_in = vld_q[k-1];
            assign cy_in  = cy_q[k-1];
            always_ff @(posedge clk) begin
               a_skew[k]   <= a_skew[k-1];
               b_skew[k]   <= b_skew[k-1];
               sum_skew[k] <= sum_full[k-1];
            end
         end

         spa_stage #(.SLICE_W(SLICE_W)) u_stage (
            .clk      (clk),
            .rst      (rst),
            .in_valid (vld_in),
            .in_carry (cy_in),
            .in_a     (a_skew[k][k*SLICE_W +: SLICE_W]),
            .in_b     (b_skew[k][k*SLICE_W +: SLICE_W]),
            .out_valid(vld_q[k]),
            .out_carry(cy_q[k]),
            .out_sum  (slc_q[k])
         );

         // lower slices delayed alongside, slice k from the stage register
         always_comb begin
            sum_full[k] = '0;
            if (k > 0) sum_full[k][k*SLICE_W-1:0] = sum_skew[k][k*SLICE_W-1:0];
            sum_full[k][k*SLICE_W +: SLICE_W] = slc_q[k];
         end
      end
   endgenerate

   assign res_vld = vld_q[STAGES-1];
   assign res_sum = sum_full[STAGES-1];
   assign res_ovf = cy_q[STAGES-1];

   // occupancy tracking for the latency bound
   logic [CNT_W-1:0] in_flight;
   always_ff @(posedge clk) begin
      if (rst) in_flight <= '0;
      else     in_flight <= in_flight + CNT_W'(op_vld) - CNT_W'(res_vld);
   end

   p_inflight_r3: assert property (@(posedge clk) disable iff (rst)
      in_flight <= CNT_W'(STAGES))
      else $error("more pairs in flight than stages");

   p_reset_clear_r6: assert property (@(posedge clk)
      rst |=> !res_vld)
      else $error("valid survived reset");
endmodule

// File: tb/serial_pipe_adder_bench.sv
module serial_pipe_adder_bench;
   localparam int OP_W    = 32;
   localparam int SLICE_W = 4;
   localparam int STAGES  = OP_W / SLICE_W;
   localparam time CLK_PERIOD = 10ns;
   localparam int NV = 14;

   // {valid, a, b}
   localparam logic [64:0] VEC [NV] = '{
      {1'b1, 32'h0000_0000, 32'h0000_0000},
      {1'b1, 32'hFFFF_FFFF, 32'h0000_0001},
      {1'b1, 32'hFFFF_FFFF, 32'hFFFF_FFFF},
      {1'b0, 32'h1111_1111, 32'h2222_2222},
      {1'b1, 32'h1234_5678, 32'h9ABC_DEF0},
      {1'b1, 32'h8000_0000, 32'h8000_0000},
      {1'b1, 32'h0000_000F, 32'h0000_0001},
      {1'b1, 32'h7FFF_FFFF, 32'h0000_0001},
      {1'b0, 32'h0000_0000, 32'h0000_0000},
      {1'b0, 32'hFFFF_FFFF, 32'hFFFF_FFFF},
      {1'b1, 32'hDEAD_BEEF, 32'h0123_4567},
      {1'b1, 32'h0F0F_0F0F, 32'hF0F0_F0F0},
      {1'b1, 32'hAAAA_AAAA, 32'h5555_5556},
      {1'b1, 32'h0000_FFFF, 32'h0000_0001}
   };

   logic            clk = 1'b0;
   logic            rst;
   logic            op_vld;
   logic [OP_W-1:0] op_a, op_b;
   logic            res_vld;
   logic [OP_W-1:0] res_sum;
   logic            res_ovf;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   serial_pipe_adder #(.OP_W(OP_W), .SLICE_W(SLICE_W)) u_serial_pipe_adder (
      .clk(clk), .rst(rst), .op_vld(op_vld), .op_a(op_a), .op_b(op_b),
      .res_vld(res_vld), .res_sum(res_sum), .res_ovf(res_ovf)
   );

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   initial begin
      #(CLK_PERIOD * 20000);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      rst = 1'b1; op_vld = 1'b0; op_a = '0; op_b = '0;
      repeat (3) @(negedge clk);
      // reset state (R6)
      check("R6 reset valid", 64'(res_vld), 64'd0);
      rst = 1'b0;

      // streamed table: inputs at negedge c, result checked at negedge c+STAGES
      for (int cyc = 0; cyc < NV + STAGES + 2; cyc++) begin
         @(negedge clk);
         if (cyc >= STAGES && cyc - STAGES < NV) begin
            logic [64:0] v;
            logic [32:0] tot;
            v   = VEC[cyc - STAGES];
            tot = {1'b0, v[63:32]} + {1'b0, v[31:0]};
            // R3 latency, R5 bubbles, R4 back to back
            check("R3/R5 valid timing", 64'(res_vld), 64'(v[64]));
            if (v[64]) begin
               check("R1 R4 R7 sum", 64'(res_sum), 64'(tot[31:0]));
               check("R2 R8 overflow", 64'(res_ovf), 64'(tot[32]));
            end
         end else begin
            check("R3 valid outside window", 64'(res_vld), 64'd0);
         end
         if (cyc < NV) begin
            op_vld = VEC[cyc][64];
            op_a   = VEC[cyc][63:32];
            op_b   = VEC[cyc][31:0];
         end else begin
            op_vld = 1'b0;
         end
      end

      // in-flight pairs dropped by reset (R6)
      for (int i = 0; i < 3; i++) begin
         op_vld = 1'b1; op_a = 32'(i + 5); op_b = 32'd7;
         @(negedge clk);
      end
      op_vld = 1'b0;
      rst = 1'b1;
      @(negedge clk);
      rst = 1'b0;
      for (int i = 0; i < STAGES + 3; i++) begin
         check("R6 flushed by reset", 64'(res_vld), 64'd0);
         @(negedge clk);
      end

      // single pair after reset, full carry chain (R7, R3)
      op_vld = 1'b1; op_a = 32'hFFFF_FFFF; op_b = 32'h0000_0001;
      @(negedge clk);
      op_vld = 1'b0;
      for (int i = 1; i < STAGES; i++) begin
         check("R3 not early", 64'(res_vld), 64'd0);
         @(negedge clk);
      end
      check("R3 on time", 64'(res_vld), 64'd1);
      check("R7 sum wraps", 64'(res_sum), 64'd0);
      check("R7 overflow", 64'(res_ovf), 64'd1);
      @(negedge clk);
      check("R5 single result", 64'(res_vld), 64'd0);

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
   end
endmodule